// File: doc/BRIEF.md
# Operand and Immediate Decode Unit

This unit turns the operand fields of one instruction into the values the rest of the pipeline needs: a fully extended immediate constant, the register read requests for the two possible source fields, and a flag that marks the instruction as not executable on this datapath. It serves a processor core that can be built with a 16-bit or a 32-bit datapath. Each instruction is either a short form, with a 4-bit operand field, or a long form, which adds a 16-bit constant. Fetch, the register file and the execution units are outside this block.

Per-instruction attribute bits come from the opcode decoder. They select zero or sign extension, mark the 4-bit field as unread, drop the 16-bit constant, let the destination field also act as a source, forbid the long form, or restrict the instruction to one datapath width. On a 32-bit datapath, a long instruction that does not read the 4-bit field uses it as the top four bits of a 20-bit constant. A field that is not read raises no read request, so it cannot cause a side effect on a read. All results are registered. They appear one cycle after the fields are presented with the valid strobe.

Top module: `opdec_unit`

## Requirements
- R1: In short form, the 4-bit operand field is sign-extended to DATA_W bits by default, which gives the range -8..7.
- R2: In long form, the 16-bit constant is sign-extended to DATA_W bits by default, which gives the range -32768..32767.
- R3: With attr_unsigned high, both constants are zero-extended: 0..15 in short form and 0..65535 in long form.
- R4: When DATA_W is at least 20, a long form with attr_no_snd high yields a 20-bit constant, {fld_a, fld_imm} with fld_a as bits 19:16. It is sign-extended by default and zero-extended under attr_unsigned. With DATA_W of 16, attr_no_snd does not change the constant.
- R5: rd_snd_en is low whenever attr_no_snd is high. Otherwise it is high, with rd_snd_idx equal to fld_a.
- R6: With attr_dst_src high in long form, rd_dst_en is high with rd_dst_idx equal to fld_dst. With attr_dst_src high in short form, the instruction is invalid.
- R7: attr_only32 on a 16-bit datapath, or attr_only16 on a 32-bit datapath, marks the instruction invalid.
- R8: In long form, attr_no_imm16 forces imm_out to zero. A long form with attr_no_long high is invalid.
- R9: When invalid is high, rd_snd_en and rd_dst_en are both low.
- R10: out_valid is high exactly in the cycle after a cycle with in_valid high. The other outputs update only on such cycles. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields are valid this cycle |
| is_long | input | 1 | 1 = long form, 0 = short form |
| fld_a | input | FLD_W | Second-source / short immediate field |
| fld_imm | input | IMM_W | Long-form 16-bit constant |
| fld_dst | input | FLD_W | Destination register field |
| attr_unsigned | input | 1 | Zero-extend immediates |
| attr_no_snd | input | 1 | The 4-bit field is not read as a register |
| attr_no_imm16 | input | 1 | The long constant is unused |
| attr_dst_src | input | 1 | The destination field also supplies a source |
| attr_no_long | input | 1 | The long form is not allowed |
| attr_only16 | input | 1 | Valid only on a 16-bit datapath |
| attr_only32 | input | 1 | Valid only on a 32-bit datapath |
| out_valid | output | 1 | Registered results are valid |
| imm_out | output | DATA_W | Extended immediate |
| rd_snd_en | output | 1 | Read request for the fld_a register |
| rd_snd_idx | output | FLD_W | Register index for that read |
| rd_dst_en | output | 1 | Read request for the fld_dst register |
| rd_dst_idx | output | FLD_W | Register index for that read |
| invalid | output | 1 | The instruction cannot execute here |

## Verification
Every result of the unit is due exactly one clock edge after the cycle in which in_valid was high. No result is ever due two cycles later or combinationally. The driver applies the fields at a falling edge and queues the expected values for the 32-bit and the 16-bit instance. The monitor then compares them at the next falling edge on which out_valid is high, so each result is sampled half a cycle after the register that produced it. Idle cycles between instructions check that out_valid drops and that the held outputs keep the last values.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  typedef struct packed {
    logic snd_en;
    logic dst_en;
  } rd_req_t;

  localparam int WIDE_IMM_W = 20;
endpackage

// File: rtl/imm_extender.sv
module imm_extender #(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 4,
  parameter int IMM_W  = 16
) (
  input  logic              is_long,
  input  logic [FLD_W-1:0]  fld_a,
  input  logic [IMM_W-1:0]  fld_imm,
  input  logic              attr_unsigned,
  input  logic              attr_no_snd,
  input  logic              attr_no_imm16,
  output logic [DATA_W-1:0] imm
);
  localparam int  JOIN_W = FLD_W + IMM_W;
  localparam bit  WIDE   = DATA_W >= JOIN_W;

  logic              sx;
  logic [DATA_W-1:0] short_v, long16_v, join_v;
  logic              use_join;

  assign sx = ~attr_unsigned;
  assign short_v  = {{(DATA_W-FLD_W){sx & fld_a[FLD_W-1]}}, fld_a};
  assign long16_v = {{(DATA_W-IMM_W){sx & fld_imm[IMM_W-1]}}, fld_imm};
  assign use_join = WIDE && attr_no_snd;

  generate
    if (WIDE) begin : g_wide
      if (DATA_W > JOIN_W) begin : g_pad
        assign join_v = {{(DATA_W-JOIN_W){sx & fld_a[FLD_W-1]}}, fld_a, fld_imm};
      end else begin : g_exact
        assign join_v = {fld_a, fld_imm};
      end
    end else begin : g_narrow
      assign join_v = long16_v;
    end
  endgenerate

  always_comb begin
    if (!is_long)           imm = short_v;
    else if (attr_no_imm16) imm = '0;
    else if (use_join)      imm = join_v;
    else                    imm = long16_v;
  end
endmodule

// File: rtl/validity_check.sv
module validity_check #(
  parameter int DATA_W = 32
) (
  input  logic is_long,
  input  logic attr_dst_src,
  input  logic attr_no_long,
  input  logic attr_only16,
  input  logic attr_only32,
  output logic bad
);
  logic wrong_width;

  generate
    if (DATA_W == 16) begin : g_w16
      assign wrong_width = attr_only32;
    end else begin : g_w32
      assign wrong_width = attr_only16;
    end
  endgenerate

  assign bad = wrong_width
             | (is_long & attr_no_long)
             | (~is_long & attr_dst_src);
endmodule

// File: rtl/src_select.sv
module src_select (
  input  logic                 bad,
  input  logic                 is_long,
  input  logic                 attr_no_snd,
  input  logic                 attr_dst_src,
  output opdec_pkg::rd_req_t   req
);
  always_comb begin
    req.snd_en = ~bad & ~attr_no_snd;
    req.dst_en = ~bad & is_long & attr_dst_src;
  end
endmodule

// File: rtl/opdec_unit.sv
module opdec_unit #(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 4,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              is_long,
  input  logic [FLD_W-1:0]  fld_a,
  input  logic [IMM_W-1:0]  fld_imm,
  input  logic [FLD_W-1:0]  fld_dst,
  input  logic              attr_unsigned,
  input  logic              attr_no_snd,
  input  logic              attr_no_imm16,
  input  logic              attr_dst_src,
  input  logic              attr_no_long,
  input  logic              attr_only16,
  input  logic              attr_only32,
  output logic              out_valid,
  output logic [DATA_W-1:0] imm_out,
  output logic              rd_snd_en,
  output logic [FLD_W-1:0]  rd_snd_idx,
  output logic              rd_dst_en,
  output logic [FLD_W-1:0]  rd_dst_idx,
  output logic              invalid
);
  logic [DATA_W-1:0]  imm_c;
  logic               bad_c;
  opdec_pkg::rd_req_t req_c;

  imm_extender #(.DATA_W(DATA_W), .FLD_W(FLD_W), .IMM_W(IMM_W)) u_imm (
    .is_long(is_long), .fld_a(fld_a), .fld_imm(fld_imm),
    .attr_unsigned(attr_unsigned), .attr_no_snd(attr_no_snd),
    .attr_no_imm16(attr_no_imm16), .imm(imm_c)
  );

  validity_check #(.DATA_W(DATA_W)) u_chk (
    .is_long(is_long), .attr_dst_src(attr_dst_src), .attr_no_long(attr_no_long),
    .attr_only16(attr_only16), .attr_only32(attr_only32), .bad(bad_c)
  );

  src_select u_src (
    .bad(bad_c), .is_long(is_long), .attr_no_snd(attr_no_snd),
    .attr_dst_src(attr_dst_src), .req(req_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      imm_out    <= '0;
      rd_snd_en  <= 1'b0;
      rd_snd_idx <= '0;
      rd_dst_en  <= 1'b0;
      rd_dst_idx <= '0;
      invalid    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        imm_out    <= imm_c;
        rd_snd_en  <= req_c.snd_en;
        rd_snd_idx <= fld_a;
        rd_dst_en  <= req_c.dst_en;
        rd_dst_idx <= fld_dst;
        invalid    <= bad_c;
      end
    end
  end

  // R9: an invalid instruction issues no register read
  p_inv_noread_r9: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (!rd_snd_en && !rd_dst_en));

  // R10: result strobe follows the input strobe by one cycle
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(imm_out) && $stable(invalid)));

  // R5: an unread field never raises a read request
  p_nosnd_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && attr_no_snd) |=> !rd_snd_en);

  // R6: short forms never read through the destination field
  p_dst_short_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_long) |=> !rd_dst_en);

  // R1: signed short constant carries the field sign into the top bit
  p_short_sign_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_long && !attr_unsigned) |=> (imm_out[DATA_W-1] == $past(fld_a[FLD_W-1])));

  // R3: unsigned short constant has no bits above the field
  p_short_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_long && attr_unsigned) |=> (imm_out[DATA_W-1:FLD_W] == '0));

  // R8: dropped long constant reads as zero
  p_noimm_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_long && attr_no_imm16) |=> (imm_out == '0));
endmodule

// File: tb/opdec_unit_test.sv
module opdec_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        in_valid = 0, is_long = 0;
  logic [3:0]  fld_a = 0, fld_dst = 0;
  logic [15:0] fld_imm = 0;
  logic a_uns = 0, a_nosnd = 0, a_noimm = 0, a_dsts = 0, a_nolong = 0, a_o16 = 0, a_o32 = 0;

  logic        ov32, ov16, se32, se16, de32, de16, iv32, iv16;
  logic [31:0] imm32;
  logic [15:0] imm16;
  logic [3:0]  si32, si16, di32, di16;

  opdec_unit #(.DATA_W(32)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_long(is_long), .fld_a(fld_a),
    .fld_imm(fld_imm), .fld_dst(fld_dst), .attr_unsigned(a_uns), .attr_no_snd(a_nosnd),
    .attr_no_imm16(a_noimm), .attr_dst_src(a_dsts), .attr_no_long(a_nolong),
    .attr_only16(a_o16), .attr_only32(a_o32), .out_valid(ov32), .imm_out(imm32),
    .rd_snd_en(se32), .rd_snd_idx(si32), .rd_dst_en(de32), .rd_dst_idx(di32), .invalid(iv32)
  );

  opdec_unit #(.DATA_W(16)) uut16 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_long(is_long), .fld_a(fld_a),
    .fld_imm(fld_imm), .fld_dst(fld_dst), .attr_unsigned(a_uns), .attr_no_snd(a_nosnd),
    .attr_no_imm16(a_noimm), .attr_dst_src(a_dsts), .attr_no_long(a_nolong),
    .attr_only16(a_o16), .attr_only32(a_o32), .out_valid(ov16), .imm_out(imm16),
    .rd_snd_en(se16), .rd_snd_idx(si16), .rd_dst_en(de16), .rd_dst_idx(di16), .invalid(iv16)
  );

  typedef struct {
    string       tag;
    logic [31:0] imm_a, imm_b;
    logic        se_a, se_b, de_a, de_b, inv_a, inv_b;
    logic [3:0]  sidx, didx;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] model_imm(int w, bit lng, bit [3:0] a, bit [15:0] im,
                                            bit uns, bit nosnd, bit noimm);
    int v;
    if (!lng) v = (!uns && a >= 8) ? int'(a) - 16 : int'(a);
    else if (noimm) v = 0;
    else if (w == 32 && nosnd) begin
      v = int'(a) * 65536 + int'(im);
      if (!uns && a >= 8) v = v - 1048576;
    end else v = (!uns && im >= 16'h8000) ? int'(im) - 65536 : int'(im);
    return (w == 16) ? (32'(v) & 32'h0000FFFF) : 32'(v);
  endfunction

  task automatic send(string tag, bit lng, bit [3:0] a, bit [15:0] im, bit [3:0] d,
                      bit uns, bit nosnd, bit noimm, bit dsts, bit nolong, bit o16, bit o32);
    exp_t e;
    bit bad32, bad16;
    bad32 = o16 || (lng && nolong) || (!lng && dsts);
    bad16 = o32 || (lng && nolong) || (!lng && dsts);
    e.tag   = tag;
    e.imm_a = model_imm(32, lng, a, im, uns, nosnd, noimm);
    e.imm_b = model_imm(16, lng, a, im, uns, nosnd, noimm);
    e.inv_a = bad32; e.inv_b = bad16;
    e.se_a  = !bad32 && !nosnd; e.se_b = !bad16 && !nosnd;
    e.de_a  = !bad32 && lng && dsts; e.de_b = !bad16 && lng && dsts;
    e.sidx  = a; e.didx = d;
    @(negedge clk);
    in_valid = 1; is_long = lng; fld_a = a; fld_imm = im; fld_dst = d;
    a_uns = uns; a_nosnd = nosnd; a_noimm = noimm; a_dsts = dsts;
    a_nolong = nolong; a_o16 = o16; a_o32 = o32;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && ov32) begin
      if (q.size() == 0) check(0, "R10", "unexpected out_valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(ov16 == 1'b1, e.tag, "out_valid16", {31'b0, ov16}, 1);
        check(imm32 == e.imm_a, e.tag, "imm32", imm32, e.imm_a);
        check({16'b0, imm16} == e.imm_b, e.tag, "imm16", {16'b0, imm16}, e.imm_b);
        check(iv32 == e.inv_a && iv16 == e.inv_b, e.tag, "invalid",
              {30'b0, iv32, iv16}, {30'b0, e.inv_a, e.inv_b});
        check(se32 == e.se_a && se16 == e.se_b && (!e.se_a || si32 == e.sidx), e.tag, "snd read",
              {27'b0, se32, se16, si32}, {27'b0, e.se_a, e.se_b, e.sidx});
        check(de32 == e.de_a && de16 == e.de_b && (!e.de_a || di32 == e.didx), e.tag, "dst read",
              {27'b0, de32, de16, di32}, {27'b0, e.de_a, e.de_b, e.didx});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!ov32 && imm32 == 0 && !se32 && !de32 && !iv32, "R10", "reset outputs",
          {27'b0, ov32, se32, de32, iv32, 1'b0}, 0);
    rst = 0;
    //      tag   lng a      imm       d     uns nsd nim dst nlg o16 o32
    send("R1", 0, 4'hF, 16'h0000, 4'h1, 0, 0, 0, 0, 0, 0, 0);
    send("R1", 0, 4'h7, 16'h1234, 4'h2, 0, 0, 0, 0, 0, 0, 0);
    send("R2", 1, 4'h3, 16'h8000, 4'h2, 0, 0, 0, 0, 0, 0, 0);
    send("R2", 1, 4'h3, 16'h7FFF, 4'h2, 0, 0, 0, 0, 0, 0, 0);
    send("R3", 0, 4'h8, 16'h0000, 4'h0, 1, 0, 0, 0, 0, 0, 0);
    send("R3", 1, 4'h5, 16'hFFFF, 4'h0, 1, 0, 0, 0, 0, 0, 0);
    send("R4", 1, 4'h9, 16'h00A5, 4'h4, 0, 1, 0, 0, 0, 0, 0);
    send("R4", 1, 4'h9, 16'h00A5, 4'h4, 1, 1, 0, 0, 0, 0, 0);
    send("R4", 1, 4'h7, 16'hFFFF, 4'h4, 0, 1, 0, 0, 0, 0, 0);
    idle();
    @(negedge clk);
    // R10: idle cycle drops the strobe and holds outputs
    check(!ov32 && !ov16 && imm32 == 32'h0007FFFF, "R10", "idle hold",
          {ov32, ov16, imm32[29:0]}, 32'h0007FFFF);
    send("R5", 0, 4'hC, 16'h0000, 4'h3, 0, 1, 0, 0, 0, 0, 0);
    send("R5", 1, 4'hD, 16'h0042, 4'h3, 0, 0, 0, 0, 0, 0, 0);
    send("R6", 1, 4'h2, 16'h0010, 4'hB, 0, 0, 0, 1, 0, 0, 0);
    send("R6", 0, 4'h2, 16'h0010, 4'hB, 0, 0, 0, 1, 0, 0, 0);
    send("R7", 0, 4'h6, 16'h0000, 4'h1, 0, 0, 0, 0, 0, 1, 0);
    send("R7", 1, 4'h6, 16'h0100, 4'h1, 0, 0, 0, 1, 0, 0, 1);
    send("R8", 1, 4'h1, 16'hBEEF, 4'h1, 0, 0, 1, 0, 0, 0, 0);
    send("R8", 1, 4'h1, 16'hBEEF, 4'h1, 0, 0, 0, 0, 1, 0, 0);
    send("R9", 1, 4'hE, 16'h0001, 4'hE, 0, 0, 0, 1, 1, 0, 0);
    send("R9", 0, 4'hE, 16'h0001, 4'hE, 0, 0, 0, 0, 0, 1, 1);
    idle();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10", "all results delivered", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule